// File: doc/BRIEF.md
# Time-Window Protected Option Register

This block holds an 8-bit option register and a small block-protect register. It enforces a different write rule for each field. Some fields are writable only during a short window after reset. The window covers a fixed number of E-clock cycles. A write to one of those fields after the window has closed is dropped. The clock-monitor enable can be changed at any time. A force bit can be set at any time but only reset clears it. While it is set, the clock monitor stays on whatever the enable bit says.

The protect register carries a guard bit for a separate nonvolatile configuration byte. The block itself does not store that byte. It forwards a write to the byte as a one-cycle write-enable pulse with its data, and only when the guard bit is clear. All state is held in flops clocked by the E clock, and reset is synchronous and active high.

A host writes through one strobe `wr` with a byte of data and a 2-bit select. The select values are: 0 for the option register, 1 for the protect register, 2 for the configuration byte and 3 for nothing.

Top module: `prot_option_reg`

## Requirements
- R1: While `rst` is high at a rising edge, the block loads these values: `option_q`=0x80, `protect_q`=0x10, `window_open`=1, `cfg_permit`=0, `clk_mon_on`=0 and `cfg_we`=0.
- R2: After `rst` falls, `window_open` reads 1 until 64 rising edges have passed with reset low, and reads 0 from the 64th edge on until the next reset. A write is inside the window when it is taken at one of those first 64 edges.
- R3: The protected option fields are bit 7 (interrupt edge select, 1 = edge) and bits 1:0 (timeout code). A write to select 0 inside the window loads them from the data. A write after the window leaves them unchanged.
- R4: Option bit 3 (clock-monitor enable) takes the written data bit on any write to select 0, whether or not the window is open.
- R5: Option bit 2 (force monitor) is set by a select-0 write with data bit 2 = 1. A write with data bit 2 = 0 does not clear it, and only reset does. `clk_mon_on` is the OR of option bits 3 and 2.
- R6: Protect bit 4 (configuration guard) loads from the data on a select-1 write inside the window and is unchanged by later writes. Every other protect bit reads 0. `cfg_permit` is the inverse of bit 4.
- R7: A select-2 write taken while the guard bit is 0 gives `cfg_we`=1 for exactly the following cycle, with `cfg_wdata` equal to the written byte. A select-2 write taken while the guard bit is 1 gives no pulse.
- R8: Option bits 6:4 always read 0. `edge_mode` equals option bit 7 and `tmo_code` equals option bits 1:0.
- R9: A write with select 3 changes no register and gives no `cfg_we` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | E clock |
| rst | input | 1 | Synchronous active-high reset |
| wr | input | 1 | Write strobe |
| sel | input | 2 | Write target: 0 option, 1 protect, 2 configuration byte, 3 none |
| wdata | input | 8 | Write data |
| option_q | output | 8 | Option register value |
| protect_q | output | 8 | Protect register value |
| edge_mode | output | 1 | Interrupt edge select (1 = edge) |
| tmo_code | output | 2 | Watchdog timeout code |
| clk_mon_on | output | 1 | Effective clock-monitor enable |
| cfg_permit | output | 1 | Configuration byte may be written |
| cfg_we | output | 1 | One-cycle write-enable for the configuration byte |
| cfg_wdata | output | 8 | Data for the configuration byte |
| window_open | output | 1 | Post-reset write window still open |

## Verification
Several rules are checked by the assertions on every cycle. Once the window has closed it never reopens before a reset. The protected option fields and the guard bit hold their values whenever the window is shut. The force bit never falls without a reset. Every configuration pulse follows a select-2 write that was made while the guard bit was clear. Other behaviour can only be shown by the bench's scenarios, because each depends on a planned sequence of events. These are the exact edge at which the window closes, the last write that is still accepted, full sweeps of data values before and after closing, and the clearing of the force bit by a second reset.

// File: rtl/po_pkg.sv
package po_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned WIN_CYCLES = 64;

  // option register layout
  localparam int unsigned OPT_EDGE   = 7;
  localparam int unsigned OPT_MON    = 3;
  localparam int unsigned OPT_FORCE  = 2;
  localparam int unsigned OPT_TMO_HI = 1;
  localparam int unsigned OPT_TMO_LO = 0;

  // protect register layout
  localparam int unsigned PROT_GUARD = 4;

  localparam logic [REG_W-1:0] OPT_RST  = 8'h80;
  localparam logic [REG_W-1:0] PROT_RST = 8'h10;

  typedef enum logic [1:0] {
    SEL_OPT  = 2'd0,
    SEL_PROT = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_NONE = 2'd3
  } po_sel_e;
endpackage

// File: rtl/po_window.sv
module po_window #(
  parameter int unsigned WINDOW = 64
) (
  input  logic clk,
  input  logic rst,
  output logic open_q
);
  localparam int unsigned CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WINDOW);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      open_q <= 1'b1;
    end else if (cnt_q != LIMIT) begin
      cnt_q  <= cnt_nxt;
      open_q <= (cnt_nxt < LIMIT);
    end
  end
endmodule

// File: rtl/po_option.sv
module po_option
  import po_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             win,
  input  logic             we,
  input  logic [REG_W-1:0] d,
  output logic [REG_W-1:0] opt_q
);
  logic       edge_q;
  logic [1:0] tmo_q;
  logic       mon_q;
  logic       force_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_q  <= OPT_RST[OPT_EDGE];
      tmo_q   <= OPT_RST[OPT_TMO_HI:OPT_TMO_LO];
      mon_q   <= OPT_RST[OPT_MON];
      force_q <= OPT_RST[OPT_FORCE];
    end else if (we) begin
      if (win) begin
        edge_q <= d[OPT_EDGE];
        tmo_q  <= d[OPT_TMO_HI:OPT_TMO_LO];
      end
      mon_q   <= d[OPT_MON];
      force_q <= force_q | d[OPT_FORCE];
    end
  end

  always_comb begin
    opt_q                        = '0;
    opt_q[OPT_EDGE]              = edge_q;
    opt_q[OPT_MON]               = mon_q;
    opt_q[OPT_FORCE]             = force_q;
    opt_q[OPT_TMO_HI:OPT_TMO_LO] = tmo_q;
  end
endmodule

// File: rtl/po_guard.sv
module po_guard
  import po_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             win,
  input  logic             we_prot,
  input  logic             we_cfg,
  input  logic [REG_W-1:0] d,
  output logic [REG_W-1:0] prot_q,
  output logic             cfg_we_q,
  output logic [REG_W-1:0] cfg_d_q
);
  logic guard_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      guard_q  <= PROT_RST[PROT_GUARD];
      cfg_we_q <= 1'b0;
      cfg_d_q  <= '0;
    end else begin
      if (we_prot && win) guard_q <= d[PROT_GUARD];
      cfg_we_q <= we_cfg && !guard_q;
      if (we_cfg && !guard_q) cfg_d_q <= d;
    end
  end

  always_comb begin
    prot_q             = '0;
    prot_q[PROT_GUARD] = guard_q;
  end
endmodule

// File: rtl/prot_option_reg.sv
module prot_option_reg
  import po_pkg::*;
#(
  parameter int unsigned WINDOW = WIN_CYCLES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [1:0]       sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] option_q,
  output logic [REG_W-1:0] protect_q,
  output logic             edge_mode,
  output logic [1:0]       tmo_code,
  output logic             clk_mon_on,
  output logic             cfg_permit,
  output logic             cfg_we,
  output logic [REG_W-1:0] cfg_wdata,
  output logic             window_open
);
  po_sel_e sel_e;
  logic    we_opt, we_prot, we_cfg;

  assign sel_e   = po_sel_e'(sel);
  assign we_opt  = wr && (sel_e == SEL_OPT);
  assign we_prot = wr && (sel_e == SEL_PROT);
  assign we_cfg  = wr && (sel_e == SEL_CFG);

  po_window #(.WINDOW(WINDOW)) u_win (
    .clk    (clk),
    .rst    (rst),
    .open_q (window_open)
  );

  po_option u_opt (
    .clk   (clk),
    .rst   (rst),
    .win   (window_open),
    .we    (we_opt),
    .d     (wdata),
    .opt_q (option_q)
  );

  po_guard u_grd (
    .clk      (clk),
    .rst      (rst),
    .win      (window_open),
    .we_prot  (we_prot),
    .we_cfg   (we_cfg),
    .d        (wdata),
    .prot_q   (protect_q),
    .cfg_we_q (cfg_we),
    .cfg_d_q  (cfg_wdata)
  );

  assign edge_mode  = option_q[OPT_EDGE];
  assign tmo_code   = option_q[OPT_TMO_HI:OPT_TMO_LO];
  assign clk_mon_on = option_q[OPT_MON] | option_q[OPT_FORCE];
  assign cfg_permit = !protect_q[PROT_GUARD];
endmodule

// File: rtl/po_checker.sv
module po_checker (
  input logic       clk,
  input logic       rst,
  input logic       wr,
  input logic [1:0] sel,
  input logic [7:0] wdata,
  input logic [7:0] option_q,
  input logic [7:0] protect_q,
  input logic       cfg_permit,
  input logic       cfg_we,
  input logic       window_open
);
  // R2
  window_stays_shut_chk: assert property (@(posedge clk) disable iff (rst)
    !window_open |=> !window_open);

  // R3
  locked_fields_chk: assert property (@(posedge clk) disable iff (rst)
    !window_open |=> $stable({option_q[7], option_q[1:0]}));

  // R4
  mon_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == 2'd0) |=> option_q[3] == $past(wdata[3]));

  // R5
  force_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    option_q[2] |=> option_q[2]);

  // R6
  guard_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !window_open |=> $stable(protect_q));

  // R7
  cfg_pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> ($past(wr && sel == 2'd2) && $past(cfg_permit)));
endmodule

bind prot_option_reg po_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr          (wr),
  .sel         (sel),
  .wdata       (wdata),
  .option_q    (option_q),
  .protect_q   (protect_q),
  .cfg_permit  (cfg_permit),
  .cfg_we      (cfg_we),
  .window_open (window_open)
);

// File: tb/tb_prot_option_reg.sv
module tb_prot_option_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr = 1'b0;
  logic [1:0] sel = 2'd3;
  logic [7:0] wdata = 8'h00;
  logic [7:0] option_q, protect_q, cfg_wdata;
  logic       edge_mode, clk_mon_on, cfg_permit, cfg_we, window_open;
  logic [1:0] tmo_code;

  int total = 0;
  int bad = 0;
  int edges = 0;

  // bench model
  logic       m_edge, m_mon, m_force, m_guard;
  logic [1:0] m_tmo;

  prot_option_reg dut (
    .clk(clk), .rst(rst), .wr(wr), .sel(sel), .wdata(wdata),
    .option_q(option_q), .protect_q(protect_q), .edge_mode(edge_mode),
    .tmo_code(tmo_code), .clk_mon_on(clk_mon_on), .cfg_permit(cfg_permit),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .window_open(window_open)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (!rst) edges++;
  endtask

  function automatic logic [7:0] m_opt();
    return {m_edge, 3'b000, m_mon, m_force, m_tmo};
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    tick(); tick();
    m_edge = 1'b1; m_tmo = 2'b00; m_mon = 1'b0; m_force = 1'b0; m_guard = 1'b1;
    rst = 1'b0;
    edges = 0;
  endtask

  task automatic check_reset();
    chk(option_q == 8'h80, "R1 option", option_q, 8'h80);
    chk(protect_q == 8'h10, "R1 protect", protect_q, 8'h10);
    chk(window_open == 1'b1, "R1 window", window_open, 1);
    chk(cfg_permit == 1'b0, "R1 permit", cfg_permit, 0);
    chk(clk_mon_on == 1'b0, "R1 monitor", clk_mon_on, 0);
    chk(cfg_we == 1'b0, "R1 cfg_we", cfg_we, 0);
  endtask

  // one write; the model is updated with the window state before the edge
  task automatic wr_op(input logic [1:0] s, input logic [7:0] d);
    bit inwin;
    inwin = (edges < 64);
    wr = 1'b1; sel = s; wdata = d;
    tick();
    wr = 1'b0; sel = 2'd3;
    if (s == 2'd0) begin
      if (inwin) begin m_edge = d[7]; m_tmo = d[1:0]; end
      m_mon = d[3];
      m_force = m_force | d[2];
    end else if (s == 2'd1) begin
      if (inwin) m_guard = d[4];
    end
  endtask

  task automatic check_regs(input string tag);
    chk(option_q == m_opt(), {tag, " option"}, option_q, m_opt());
    chk(protect_q == {3'b000, m_guard, 4'b0000}, {tag, " protect"}, protect_q,
        {3'b000, m_guard, 4'b0000});
    // R8
    chk(edge_mode == m_edge && tmo_code == m_tmo, "R8 decode",
        {edge_mode, tmo_code}, {m_edge, m_tmo});
    // R5
    chk(clk_mon_on == (m_mon | m_force), "R5 monitor out", clk_mon_on, m_mon | m_force);
    // R6
    chk(cfg_permit == !m_guard, "R6 permit", cfg_permit, !m_guard);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    check_reset();

    // window phase: all protected fields writable
    wr_op(2'd0, 8'h07); check_regs("R3 in-window");
    wr_op(2'd0, 8'h7A); check_regs("R8 unused bits");
    wr_op(2'd1, 8'hEF); check_regs("R6 in-window");
    wr_op(2'd3, 8'hFF);
    check_regs("R9 select none");
    chk(cfg_we == 1'b0, "R9 no pulse", cfg_we, 0);
    wr_op(2'd0, 8'h81); check_regs("R3 in-window");
    while (edges < 70) tick();
    chk(window_open == 1'b0, "R2 closed", window_open, 0);

    // exhaustive sweep of option writes after the window
    for (int v = 0; v < 256; v++) begin
      wr_op(2'd0, v[7:0]);
      check_regs("R3 R4 R5 sweep");
    end
    // protect writes after the window are ignored
    for (int v = 0; v < 256; v += 5) begin
      wr_op(2'd1, v[7:0]);
      check_regs("R6 locked");
    end
    // configuration writes with the guard clear
    for (int v = 0; v < 256; v += 3) begin
      wr_op(2'd2, v[7:0]);
      chk(cfg_we == 1'b1 && cfg_wdata == v[7:0], "R7 pulse", {cfg_we, cfg_wdata},
          {1'b1, v[7:0]});
      tick();
      chk(cfg_we == 1'b0, "R7 single cycle", cfg_we, 0);
    end
    for (int v = 0; v < 256; v += 7) begin
      wr_op(2'd3, v[7:0]);
      chk(cfg_we == 1'b0, "R9 no pulse", cfg_we, 0);
      check_regs("R9 select none");
    end

    // second reset clears sticky force
    do_reset();
    check_reset();
    chk(option_q[2] == 1'b0, "R5 force cleared", option_q[2], 0);
    wr_op(2'd2, 8'h5A);
    chk(cfg_we == 1'b0, "R7 guarded", cfg_we, 0);
    tick();
    chk(cfg_we == 1'b0, "R7 guarded", cfg_we, 0);

    // exact closing edge
    do_reset();
    for (int i = 1; i <= 63; i++) begin
      tick();
      chk(window_open == 1'b1, "R2 open", window_open, 1);
    end
    wr_op(2'd0, 8'h03);   // taken at edge 64: last accepted
    chk(window_open == 1'b0, "R2 closes at 64", window_open, 0);
    check_regs("R3 last edge");
    chk(option_q == 8'h03, "R3 last edge value", option_q, 8'h03);
    wr_op(2'd0, 8'h82);   // edge 65: protected fields ignored
    chk(option_q == 8'h03, "R3 after close", option_q, 8'h03);
    wr_op(2'd1, 8'h00);
    chk(protect_q == 8'h10, "R6 after close", protect_q, 8'h10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule